// File: doc/BRIEF.md
# Doorbell and Inter-Processor Trigger Unit

This block holds, for each of up to four processors, a 32-bit doorbell cause register and a 32-bit enable register. Any agent can ring a doorbell on a chosen group of processors through one shared trigger register. A processor sending an inter-processor interrupt writes the trigger through the register bus. A bus master delivering a message-signalled interrupt writes it through a dedicated inbound message port. One trigger word carries both the doorbell number and a bitmap of the target processors.

Each processor's doorbells fall into two groups. Doorbells 0 to 7 are for inter-processor signalling and doorbells 16 to 31 are for message-signalled interrupts. Each group drives its own registered summary line toward the interrupt controller. Software clears a cause bit by writing a zero to it. Accesses to the cause and enable registers are steered to the bank of the processor named on the CPU-id sideband of the register bus.

Top module: `doorbell_unit`

## Requirements
- R1: After reset, every cause and enable register reads 0 and every summary line (`ipi_irq`, `msi_irq`) is low.
- R2: A bus write to offset 0x04 takes the doorbell number from wdata[4:0] and the target bitmap from wdata[11:8], where bit 8+c selects CPU c. It sets that doorbell bit in the cause register of every targeted CPU and leaves every other cause bit unchanged.
- R3: A message-port word (1 << (8+c)) | (16+n) sets cause bit 16+n of CPU c only. A bus trigger and a message trigger in the same cycle both take effect.
- R4: A bus write to offset 0x08 acts only on the cause register of the CPU given by `bus_cpu_id`. Each bit written as 0 is cleared and each bit written as 1 keeps its value.
- R5: Offset 0x0C is a fully readable and writable 32-bit enable register, banked by `bus_cpu_id`. Read data appears on `bus_rdata` the cycle after the read request. A read of any offset other than 0x08 or 0x0C returns 0.
- R6: `ipi_irq[c]` is high exactly when, one cycle earlier, CPU c had a cause bit in 0..7 that was also set in its enable register (group mask 0x000000FF).
- R7: `msi_irq[c]` follows the same rule for cause bits 16..31 (group mask 0xFFFF0000).
- R8: When a trigger sets a bit in the same cycle that a cause write clears it, the bit ends up set.
- R9: Doorbells 8 to 15 can be set by a trigger and read back, but they never drive a summary line, even when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_cpu_id | input | 2 | Requesting CPU; selects the per-CPU bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| msg_valid | input | 1 | Message-signalled write to the trigger |
| msg_data | input | 32 | Trigger word from the message port |
| ipi_irq | output | 4 | Per-CPU summary of the inter-processor group |
| msi_irq | output | 4 | Per-CPU summary of the message-signalled group |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same cause bit in the same cycle. The register bus alone carries one access per cycle, so the bench drives a message-port trigger in the very cycle that a bus write clears the same CPU's cause register. It then reads the bank back. Random rounds mix bus triggers with random bitmaps, including the reserved numbers 8 to 15, message words, cause clears and enable writes. After each round every bank is read back and both summary lines are compared with a bench model.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int unsigned DB_W = 32;
  localparam int unsigned NUM_W = 5;
  localparam int unsigned MAP_LSB = 8;
  localparam logic [7:0] OFFS_TRIG = 8'h04;
  localparam logic [7:0] OFFS_CAUSE = 8'h08;
  localparam logic [7:0] OFFS_ENABLE = 8'h0C;
  localparam logic [DB_W-1:0] GRP_IPI = 32'h0000_00FF;
  localparam logic [DB_W-1:0] GRP_MSI = 32'hFFFF_0000;
endpackage

// File: rtl/db_trigger_decode.sv
module db_trigger_decode
  import db_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4
) (
  input  logic                           valid,
  input  logic [DB_W-1:0]                word,
  output logic [NUM_CPUS-1:0][DB_W-1:0]  set_vec
);
  logic [DB_W-1:0] bit_sel;
  assign bit_sel = DB_W'(1) << word[NUM_W-1:0];

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      set_vec[c] = (valid && word[MAP_LSB + c]) ? bit_sel : '0;
    end
  end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
  import db_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [DB_W-1:0] set_bits,
  input  logic            clr_en,
  input  logic            en_we,
  input  logic [DB_W-1:0] wdata,
  output logic [DB_W-1:0] cause_q,
  output logic [DB_W-1:0] enable_q,
  output logic            ipi_irq,
  output logic            msi_irq
);
  logic [DB_W-1:0] kept;
  logic [DB_W-1:0] live;

  assign kept = clr_en ? (cause_q & wdata) : cause_q;
  assign live = cause_q & enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q  <= '0;
      enable_q <= '0;
      ipi_irq  <= 1'b0;
      msi_irq  <= 1'b0;
    end else begin
      cause_q <= kept | set_bits;
      if (en_we) enable_q <= wdata;
      ipi_irq <= |(live & GRP_IPI);
      msi_irq <= |(live & GRP_MSI);
    end
  end

  logic chk_arm;
  always_ff @(posedge clk) begin
    if (rst) chk_arm <= 1'b0;
    else     chk_arm <= 1'b1;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst || !chk_arm)
    (|set_bits) |=> ((cause_q & $past(set_bits)) == $past(set_bits)));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst || !chk_arm)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_bits)) == '0));

  p_ipi_line_r6: assert property (@(posedge clk) disable iff (rst || !chk_arm)
    (|(cause_q & enable_q & GRP_IPI)) |=> ipi_irq);

  p_msi_line_r7: assert property (@(posedge clk) disable iff (rst || !chk_arm)
    (|(cause_q & enable_q & GRP_MSI)) |=> msi_irq);

  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (rst || !chk_arm)
    ((cause_q & enable_q & (GRP_IPI | GRP_MSI)) == '0) |=> (!ipi_irq && !msi_irq));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import db_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CPU_W-1:0]    bus_cpu_id,
  input  logic [DB_W-1:0]     bus_wdata,
  output logic [DB_W-1:0]     bus_rdata,
  input  logic                msg_valid,
  input  logic [DB_W-1:0]     msg_data,
  output logic [NUM_CPUS-1:0] ipi_irq,
  output logic [NUM_CPUS-1:0] msi_irq
);
  logic hit_trig, hit_cause, hit_en;
  assign hit_trig  = bus_valid && (bus_addr == ADDR_W'(OFFS_TRIG));
  assign hit_cause = bus_valid && (bus_addr == ADDR_W'(OFFS_CAUSE));
  assign hit_en    = bus_valid && (bus_addr == ADDR_W'(OFFS_ENABLE));

  logic [NUM_CPUS-1:0][DB_W-1:0] set_bus, set_msg;
  logic [NUM_CPUS-1:0][DB_W-1:0] cause_all, enable_all;

  db_trigger_decode #(.NUM_CPUS(NUM_CPUS)) u_dec_bus (
    .valid(hit_trig && bus_write), .word(bus_wdata), .set_vec(set_bus));
  db_trigger_decode #(.NUM_CPUS(NUM_CPUS)) u_dec_msg (
    .valid(msg_valid), .word(msg_data), .set_vec(set_msg));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic mine;
    assign mine = (bus_cpu_id == CPU_W'(c));
    db_cpu_bank u_bank (
      .clk(clk), .rst(rst),
      .set_bits(set_bus[c] | set_msg[c]),
      .clr_en(hit_cause && bus_write && mine),
      .en_we(hit_en && bus_write && mine),
      .wdata(bus_wdata),
      .cause_q(cause_all[c]), .enable_q(enable_all[c]),
      .ipi_irq(ipi_irq[c]), .msi_irq(msi_irq[c]));
  end

  logic [DB_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (bus_cpu_id == CPU_W'(c)) begin
        if (hit_cause) rd_mux = cause_all[c];
        if (hit_en)    rd_mux = enable_all[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
  end

  p_rdata_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !hit_cause && !hit_en) |=> (bus_rdata == '0));
endmodule

// File: tb/doorbell_unit_bench.sv
module doorbell_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0, msg_valid = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [1:0] bus_cpu_id = '0;
  logic [31:0] bus_wdata = '0, msg_data = '0;
  logic [31:0] bus_rdata;
  logic [3:0] ipi_irq, msi_irq;

  always #10 clk = ~clk;

  doorbell_unit u_doorbell_unit (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_cpu_id(bus_cpu_id), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_data(msg_data),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq));

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] m_cause [4];
  logic [31:0] m_en [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model_trig(input logic [31:0] w);
    for (int c = 0; c < 4; c++)
      if (w[8 + c]) m_cause[c][w[4:0]] = 1'b1;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input int c, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_cpu_id = 2'(c); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input int c, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_cpu_id = 2'(c);
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic msg_wr(input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1; msg_data = d;
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      bus_rd(8'h08, c, d); chk({tag, " R4 cause"}, d, m_cause[c]);
      bus_rd(8'h0C, c, d); chk({tag, " R5 enable"}, d, m_en[c]);
      chk({tag, " R6 ipi line"}, 32'(ipi_irq[c]), 32'(|(m_cause[c] & m_en[c] & 32'h0000_00FF)));
      chk({tag, " R7 msi line"}, 32'(msi_irq[c]), 32'(|(m_cause[c] & m_en[c] & 32'hFFFF_0000)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, w;
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin m_cause[c] = '0; m_en[c] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    check_state("R1 reset");
    chk("R1 ipi lines after reset", 32'(ipi_irq), 0);
    chk("R1 msi lines after reset", 32'(msi_irq), 0);

    // R5: banked enable writes
    for (int c = 0; c < 4; c++) begin
      w = $urandom; bus_wr(8'h0C, c, w); m_en[c] = w;
    end
    check_state("R5 banked enable");

    // R2: bus trigger doorbell 3 on CPUs 0 and 2
    bus_wr(8'h04, 0, 32'h0000_0503); model_trig(32'h0000_0503);
    m_en[0] = 32'hFFFF_FFFF; bus_wr(8'h0C, 0, m_en[0]);
    check_state("R2 bus trigger");

    // R3: message word rings MSI doorbell 5 on CPU 1, with bus trigger same cycle
    @(negedge clk);
    msg_valid = 1; msg_data = (32'd1 << 9) | 32'd21;
    bus_valid = 1; bus_write = 1; bus_addr = 8'h04; bus_wdata = 32'h0000_0206;
    @(negedge clk);
    msg_valid = 0; bus_valid = 0; bus_write = 0;
    model_trig((32'd1 << 9) | 32'd21); model_trig(32'h0000_0206);
    chk("R3 msi bit", 32'(1'b1), 32'(m_cause[1][21]));
    check_state("R3 message trigger");

    // R4: clear with zeros on CPU 0 only; CPU 2 keeps bit 3
    bus_wr(8'h08, 0, 32'hFFFF_FFF7); m_cause[0] &= 32'hFFFF_FFF7;
    check_state("R4 write-zero clear");

    // R8: clear all on CPU 3 while message rings doorbell 20 on CPU 3
    bus_wr(8'h04, 0, 32'h0000_0814); model_trig(32'h0000_0814);
    bus_wr(8'h04, 0, 32'h0000_0801); model_trig(32'h0000_0801);
    @(negedge clk);
    msg_valid = 1; msg_data = (32'd1 << 11) | 32'd20;
    bus_valid = 1; bus_write = 1; bus_addr = 8'h08; bus_cpu_id = 2'd3; bus_wdata = 32'h0;
    @(negedge clk);
    msg_valid = 0; bus_valid = 0; bus_write = 0;
    m_cause[3] = 32'h0010_0000;
    bus_rd(8'h08, 3, d);
    chk("R8 set wins over clear", d, 32'h0010_0000);
    check_state("R8 collision");

    // R9: reserved doorbell 10 on all CPUs with everything enabled
    for (int c = 0; c < 4; c++) begin
      bus_wr(8'h08, c, 32'h0); m_cause[c] = '0;
      bus_wr(8'h0C, c, 32'hFFFF_FFFF); m_en[c] = 32'hFFFF_FFFF;
    end
    bus_wr(8'h04, 0, 32'h0000_0F0A); model_trig(32'h0000_0F0A);
    check_state("R9 reserved");
    chk("R9 no ipi line", 32'(ipi_irq), 0);
    chk("R9 no msi line", 32'(msi_irq), 0);

    // R5: other offsets read zero
    bus_rd(8'h04, 0, d); chk("R5 trigger reads 0", d, 0);
    bus_rd(8'h40, 1, d); chk("R5 unmapped reads 0", d, 0);

    // random rounds
    for (int i = 0; i < 300; i++) begin
      int op, c;
      op = int'($urandom_range(0, 4));
      c = int'($urandom_range(0, 3));
      w = $urandom;
      case (op)
        0: begin bus_wr(8'h04, c, w); model_trig(w); end
        1: begin
          w = (32'd1 << (8 + c)) | (32'd16 + 32'($urandom_range(0, 15)));
          msg_wr(w); model_trig(w);
        end
        2: begin bus_wr(8'h08, c, w); m_cause[c] &= w; end
        3: begin bus_wr(8'h0C, c, w); m_en[c] = w; end
        default: begin
          logic [31:0] mw;
          mw = $urandom;
          @(negedge clk);
          msg_valid = 1; msg_data = mw;
          bus_valid = 1; bus_write = 1; bus_addr = 8'h08; bus_cpu_id = 2'(c); bus_wdata = w;
          @(negedge clk);
          msg_valid = 0; bus_valid = 0; bus_write = 0;
          m_cause[c] &= w; model_trig(mw);
        end
      endcase
      if (i % 5 == 4) check_state("R2 R8 random");
    end
    check_state("R6 R7 final");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule